// File: doc/BRIEF.md
# Multi-Format Serial Converter Word Receiver

This block takes a framed serial stream meant for a 14-bit digital-to-analog converter and turns it into a parallel code with a single-cycle load strobe. The strobe feeds the converter's input holding stage. All logic runs on one system clock. The serial clock, the active-low frame marker and the data line are brought into that domain through a two-flop synchroniser. The serial clock is then watched for falling edges, so it has to run well below the system clock.

Every frame is 16 serial bits long and carries 14 code bits plus two pad bits that are discarded. Two static mode pins select one of four layouts. `order_msb` picks the bit order: 0 means the least significant bit arrives first, 1 means the most significant bit arrives first. `pad_tail` picks where the two pad bits sit: 0 puts them at stream positions 1–2, 1 puts them at positions 15–16. Both pins are captured when a frame starts.

Top module: `dac_frame_rx`

## Requirements
- R1: While `rst_n` is low, and until the first strobe after reset, `code` is 0 and `load` is 0.
- R2: With `order_msb`=0 and `pad_tail`=0, stream bits 1–2 are ignored. Stream bit 3 becomes code[0] and stream bit 16 becomes code[13].
- R3: With `order_msb`=0 and `pad_tail`=1, stream bit 1 becomes code[0] and stream bit 14 becomes code[13]. Stream bits 15–16 are ignored.
- R4: With `order_msb`=1 and `pad_tail`=0, stream bits 1–2 are ignored. Stream bit 3 becomes code[13] and stream bit 16 becomes code[0].
- R5: With `order_msb`=1 and `pad_tail`=1, stream bit 1 becomes code[13] and stream bit 14 becomes code[0]. Stream bits 15–16 are ignored.
- R6: `load` is high for exactly one system clock per completed frame. It rises only after the sixteenth serial-clock falling edge of a frame that is in progress.
- R7: A serial-clock falling edge with `sync_n` high while no frame is in progress is ignored. It produces no strobe and does not disturb the next frame.
- R8: The mode pins are captured at the first falling edge of a frame. Changing them in the middle of a frame does not affect that frame's code.
- R9: `code` changes only in the cycle where `load` is high, and otherwise holds the last code delivered.
- R10: A frame may begin on the falling edge right after the sixteenth edge of the previous frame, if `sync_n` is low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame marker, sampled at a frame's first falling edge |
| sdata | input | 1 | Serial data |
| order_msb | input | 1 | Bit order select: 1 = most significant bit first |
| pad_tail | input | 1 | Pad position select: 1 = pad bits trail the data |
| code | output | 14 | Assembled converter code |
| load | output | 1 | One-cycle strobe marking a new `code` |

## Verification
The hardest conditions to reach from the ports are a change of mode pins inside a frame and stray serial-clock edges between frames. Both only matter if they leave no trace in a later code. The driver flips both mode pins after the eighth bit of selected frames and expects the code decoded with the mode that was in force at the frame start. It also pulses the serial clock with `sync_n` high before a frame, so the scoreboard would see a stray or shifted code. Frames are also sent back to back with `sync_n` held low, and the pad bits carry values opposite to the neighbouring data so that a misplaced window shows up.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
    // mode captured at frame start
    typedef struct packed {
        logic msb_first;   // 1: first data bit is the most significant
        logic pad_trail;   // 1: the two pad bits close the frame
    } mode_t;
endpackage

// File: rtl/dfr_sync.sv
module dfr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dfr_fall_det.sv
module dfr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/dfr_unpack.sv
module dfr_unpack #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_BITS  = 14
) (
    input  logic [FRAME_BITS-1:0] frame,   // first received bit at the top
    input  dfr_pkg::mode_t        mode,
    output logic [CODE_BITS-1:0]  code
);
    logic [CODE_BITS-1:0] window;

    always_comb begin
        if (mode.pad_trail) window = frame[FRAME_BITS-1 -: CODE_BITS];
        else                window = frame[CODE_BITS-1:0];
        if (mode.msb_first) begin
            code = window;
        end else begin
            for (int i = 0; i < CODE_BITS; i++) begin
                code[i] = window[CODE_BITS-1-i];
            end
        end
    end
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
    parameter int FRAME_BITS  = 16,
    parameter int CODE_BITS   = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 sync_n,
    input  logic                 sdata,
    input  logic                 order_msb,
    input  logic                 pad_tail,
    output logic [CODE_BITS-1:0] code,
    output logic                 load
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
        dfr_pkg::mode_t        mode;
        logic [CODE_BITS-1:0]  code;
        logic                  load;
    } st_t;

    st_t st_d, st_q;

    logic sclk_s, sync_s, sdata_s, fall;
    logic [FRAME_BITS-1:0] frame_full;
    logic [CODE_BITS-1:0]  code_unp;

    dfr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sync_n, sdata}),
        .q     ({sclk_s, sync_s, sdata_s})
    );

    dfr_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .fall  (fall)
    );

    assign frame_full = {st_q.shreg[FRAME_BITS-2:0], sdata_s};

    dfr_unpack #(
        .FRAME_BITS (FRAME_BITS),
        .CODE_BITS  (CODE_BITS)
    ) u_unpack (
        .frame (frame_full),
        .mode  (st_q.mode),
        .code  (code_unp)
    );

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (fall && (st_q.busy || !sync_s)) begin
            st_d.shreg = frame_full;
            if (!st_q.busy) begin
                st_d.busy           = 1'b1;
                st_d.cnt            = CNT_W'(1);
                st_d.mode.msb_first = order_msb;
                st_d.mode.pad_trail = pad_tail;
            end else if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.code = code_unp;
                st_d.load = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.code;
    assign load = st_q.load;
endmodule

// File: rtl/dfr_chk.sv
module dfr_chk #(
    parameter int CODE_BITS = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load,
    input logic [CODE_BITS-1:0] code,
    input logic                 busy,
    input logic                 fall,
    input logic                 sync_s,
    input dfr_pkg::mode_t       mode
);
    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |-> (code == '0 && !load));

    // R6
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R6
    load_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(busy));

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fall && sync_s) |=> (!busy && !load));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> $stable(code));
endmodule

bind dac_frame_rx dfr_chk #(.CODE_BITS(CODE_BITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .code   (code),
    .busy   (st_q.busy),
    .fall   (fall),
    .sync_s (sync_s),
    .mode   (st_q.mode)
);

// File: tb/dac_frame_rx_tb.sv
module dac_frame_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sync_n = 1'b1;
    logic        sdata = 1'b0;
    logic        order_msb = 1'b0;
    logic        pad_tail = 1'b0;
    logic [13:0] code;
    logic        load;

    int n_chk = 0;
    int n_bad = 0;
    int n_frames = 0;
    int n_loads = 0;
    int stab_bad = 0;
    int pulse_bad = 0;
    logic [13:0] exp_q[$];
    logic [13:0] last_code = '0;
    logic        prev_load = 1'b0;

    always #2 clk = ~clk;

    dac_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdata(sdata),
        .order_msb(order_msb), .pad_tail(pad_tail), .code(code), .load(load)
    );

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: scoreboard compare plus pulse width and hold tracking
    always @(negedge clk) begin
        if (rst_n) begin
            if (load) begin
                n_loads++;
                if (prev_load) pulse_bad++;
                if (exp_q.size() == 0) begin
                    check("R6 unexpected load", code, 14'h0);
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    check("R2-5/R7/R8/R10 code", code, e);
                end
                last_code = code;
            end else if (code !== last_code) begin
                stab_bad++;
            end
            prev_load = load;
        end
    end

    task automatic half_bit(input logic lvl);
        sclk = lvl;
        repeat (8) @(negedge clk);
    endtask

    // stream bit k (1..16) for a given code and layout, per R2-R5
    function automatic logic stream_bit(input logic [13:0] c, input logic msb,
                                        input logic trail, input int k);
        int idx;
        if (!trail) begin
            if (k <= 2) return ~c[msb ? 13 : 0];
            idx = k - 3;
        end else begin
            if (k >= 15) return ~c[msb ? 0 : 13];
            idx = k - 1;
        end
        return msb ? c[13-idx] : c[idx];
    endfunction

    task automatic send_frame(input logic [13:0] c, input logic msb, input logic trail,
                              input bit flip_mid, input bit keep_sync);
        order_msb = msb;
        pad_tail  = trail;
        exp_q.push_back(c);
        n_frames++;
        for (int k = 1; k <= 16; k++) begin
            sdata = stream_bit(c, msb, trail, k);
            if (k == 1) sync_n = 1'b0;
            half_bit(1'b1);
            half_bit(1'b0);
            if (k == 1 && !keep_sync) sync_n = 1'b1;
            if (k == 8 && flip_mid) begin
                order_msb = ~msb;
                pad_tail  = ~trail;
            end
        end
        sclk = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset code", code, 14'h0);
        check("R1 reset load", {13'h0, load}, 14'h0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 idle after reset", {13'h0, load}, 14'h0);

        // R2
        send_frame(14'h2A5C, 1'b0, 1'b0, 0, 0);
        send_frame(14'h0001, 1'b0, 1'b0, 0, 0);
        // R3
        send_frame(14'h1234, 1'b0, 1'b1, 0, 0);
        send_frame(14'h2000, 1'b0, 1'b1, 0, 0);
        // R4
        send_frame(14'h3FFF, 1'b1, 1'b0, 0, 0);
        send_frame(14'h0F0F, 1'b1, 1'b0, 0, 0);
        // R5
        send_frame(14'h0000, 1'b1, 1'b1, 0, 0);
        send_frame(14'h1C3A, 1'b1, 1'b1, 0, 0);

        // R7: stray edges with sync_n high between frames
        repeat (10) @(negedge clk);
        sync_n = 1'b1;
        for (int p = 0; p < 5; p++) begin
            sdata = p[0];
            half_bit(1'b1);
            half_bit(1'b0);
        end
        sclk = 1'b1;
        repeat (10) @(negedge clk);
        send_frame(14'h0AB3, 1'b0, 1'b0, 0, 0);

        // R8: mode pins flipped mid-frame
        send_frame(14'h3501, 1'b0, 1'b1, 1, 0);
        send_frame(14'h06E9, 1'b1, 1'b0, 1, 0);

        // R10: back-to-back frames with sync_n low throughout
        send_frame(14'h1111, 1'b1, 1'b1, 0, 1);
        send_frame(14'h2222, 1'b0, 1'b0, 0, 1);
        send_frame(14'h3333, 1'b1, 1'b0, 0, 0);

        repeat (40) @(negedge clk);
        check("R6 all expected codes delivered", 14'(exp_q.size()), 14'h0);
        check("R6 one load per frame", 14'(n_loads), 14'(n_frames));
        check("R6 load single cycle", 14'(pulse_bad), 14'h0);
        check("R9 code holds between loads", 14'(stab_bad), 14'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule